// File: doc/BRIEF.md
# Radix-4 Booth Serial-Parallel Multiply-Accumulate Unit

This block forms scalar products, the sum of a series of signed coefficient-by-sample terms, for FIR and IIR filter datapaths. For each term, one operand is loaded in parallel into a shift register. That register is then consumed two bits per clock through an overlapping radix-4 Booth recoder. The other operand stays in a parallel holding register. Each recoded digit selects zero, plus or minus one, or plus or minus two times the held operand. The selection is added into a partial-product register that shifts right by two bits per step. The two bits that drop off the bottom leave the block on a serial output as the product is built.

When the last digit has been used, the finished product is added into a full-precision accumulator. The block then pulses a completion flag. A swap input decides, per term, which operand takes the recoded serial path. A clear input restarts the running sum. Each operand is read exactly once per term, at the load.

Top module: `booth_sp_mac`

## Requirements
- R1: After reset, the accumulator reads zero, and both the busy and done outputs are low.
- R2: Each loaded term contributes exactly the two's-complement product of the signed W-bit coefficient and the signed W-bit data word. This includes terms where one or both operands hold the most negative value.
- R3: The accumulator is 2*W + ceil(log2(MAX_TERMS)) bits wide, and sums up to MAX_TERMS products without truncation or overflow. It changes only in the cycle that completes a term, or on a clear.
- R4: A multiplication takes ceil(W/2) digit steps, half the operand width rounded up. `done` is high for exactly one cycle, ceil(W/2)+1 clock edges after the edge that accepts the load. The updated sum is visible in that same cycle, and `busy` is already low.
- R5: With `swap` high at the load, the data word takes the recoded serial path and the coefficient is held in parallel. The resulting product is identical.
- R6: During each digit step, `ser_valid` is high and `ser_bits` carries the next two product bits, least significant pair first. Over ceil(W/2) steps these form the low 2*ceil(W/2) bits of the product.
- R7: `clear` zeroes the accumulator on the next edge. When `clear` is given together with a load, the sum restarts with that term as its first.
- R8: A `load` raised while `busy` is high is ignored: the term in progress completes with its original operands, and only one `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture both operands and start a term (only when idle) |
| clear | input | 1 | Zero the running sum |
| swap | input | 1 | Route the data word, instead of the coefficient, to the recoder |
| coef | input | W | Signed coefficient |
| data | input | W | Signed data word |
| acc | output | 2*W+ceil(log2(MAX_TERMS)) | Signed full-precision running sum |
| ser_bits | output | 2 | Low product bit pair produced in the current step |
| ser_valid | output | 1 | `ser_bits` is valid |
| busy | output | 1 | A term is in progress |
| done | output | 1 | One-cycle pulse when the sum includes the new term |

## Verification
The bench builds the unit with W = 19 and MAX_TERMS = 16. The odd width forces the recoder input to be sign-extended to 20 bits, which gives ten digit steps, a 42-bit sum, and a 20-bit serial stream checked against the reference product. Operands stay within 64-bit arithmetic, so the bench can compare exactly. Sixteen terms of (-2^18)*(-2^18) bring the sum to 2^40, one bit short of the accumulator's sign, so the no-overflow claim is tested at its edge.

// File: rtl/booth_sp_mac.sv
module booth_sp_mac #(
  parameter int W = 20,
  parameter int MAX_TERMS = 64,
  localparam int AW = 2 * W + $clog2(MAX_TERMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic          swap,
  input  logic [W-1:0]  coef,
  input  logic [W-1:0]  data,
  output logic [AW-1:0] acc,
  output logic [1:0]    ser_bits,
  output logic          ser_valid,
  output logic          busy,
  output logic          done
);

  localparam int WE   = W + (W % 2);
  localparam int ND   = WE / 2;
  localparam int HW   = W + 3;
  localparam int CNTW = $clog2(ND + 1);

  logic [WE-1:0]          ser_q;
  logic                   prev_q;
  logic [W-1:0]           par_q;
  logic signed [HW-1:0]   hi_q;
  logic [WE-1:0]          lo_q;
  logic [CNTW-1:0]        cnt_q;
  logic                   fin_q;
  logic                   busy_q;
  logic                   done_q;
  logic [1:0]             sbits_q;
  logic                   sval_q;
  logic signed [AW-1:0]   acc_q;

  wire         start    = load && !busy_q;
  wire [W-1:0] ser_src  = swap ? data : coef;
  wire [W-1:0] par_src  = swap ? coef : data;
  wire [WE-1:0] ser_init = WE'(signed'(ser_src));
  wire [2:0]   grp      = {ser_q[1:0], prev_q};

  logic signed [HW-1:0] one_x, two_x, pick, sum_s;
  logic signed [AW-1:0] prod_ext;

  always_comb begin
    one_x = HW'(signed'(par_q));
    two_x = one_x <<< 1;
    unique case (grp)
      3'b001, 3'b010: pick = one_x;
      3'b011:         pick = two_x;
      3'b100:         pick = -two_x;
      3'b101, 3'b110: pick = -one_x;
      default:        pick = '0;
    endcase
    sum_s    = hi_q + pick;
    prod_ext = AW'(signed'({hi_q, lo_q}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q   <= '0;
      prev_q  <= 1'b0;
      par_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sbits_q <= '0;
      sval_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      sval_q <= 1'b0;
      if (start) begin
        ser_q  <= ser_init;
        prev_q <= 1'b0;
        par_q  <= par_src;
        hi_q   <= '0;
        lo_q   <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && !fin_q) begin
        ser_q   <= {{2{ser_q[WE-1]}}, ser_q[WE-1:2]};
        prev_q  <= ser_q[1];
        hi_q    <= sum_s >>> 2;
        lo_q    <= {sum_s[1:0], lo_q[WE-1:2]};
        sbits_q <= sum_s[1:0];
        sval_q  <= 1'b1;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CNTW'(ND - 1)) fin_q <= 1'b1;
      end else if (fin_q) begin
        fin_q  <= 1'b0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= (clear ? '0 : acc_q) + (fin_q ? prod_ext : '0);
  end

  assign acc       = acc_q;
  assign ser_bits  = sbits_q;
  assign ser_valid = sval_q;
  assign busy      = busy_q;
  assign done      = done_q;

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= ND));

  p_ser_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sval_q |-> busy_q);

  p_hold_operand_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && load) |=> $stable(par_q));

  p_acc_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fin_q) && !$past(clear)) |-> $stable(acc_q));

endmodule

// File: tb/booth_sp_mac_test.sv
module booth_sp_mac_test;
  localparam int W  = 19;
  localparam int MT = 16;
  localparam int AW = 2 * W + $clog2(MT);
  localparam int ND = (W + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, clear = 1'b0, swap = 1'b0;
  logic [W-1:0] coef = '0, data = '0;
  logic [AW-1:0] acc;
  logic [1:0] ser_bits;
  logic ser_valid, busy, done;

  int checks = 0;
  int fails = 0;
  longint model = 0;
  int seed = 32'h1234_5678;

  localparam longint MINV = -(64'sd1 <<< (W - 1));
  localparam longint MAXV = (64'sd1 <<< (W - 1)) - 1;

  always #5 clk = ~clk;

  booth_sp_mac #(.W(W), .MAX_TERMS(MT)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .clear(clear), .swap(swap),
    .coef(coef), .data(data), .acc(acc), .ser_bits(ser_bits),
    .ser_valid(ser_valid), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint acc_val();
    logic signed [AW-1:0] s;
    s = acc;
    return longint'(s);
  endfunction

  task automatic mac(input longint c, input longint d, input bit clr, input bit swp, input bit poke);
    longint p;
    logic [2*ND-1:0] got;
    p = c * d;
    if (clr) model = 0;
    model += p;
    @(negedge clk);
    coef = W'(c); data = W'(d); clear = clr; swap = swp; load = 1'b1;
    @(negedge clk);
    load = 1'b0; clear = 1'b0; swap = 1'b0;
    chk(busy == 1'b1, "R4 busy after load", longint'(busy), 1);
    for (int k = 0; k < ND; k++) begin
      @(negedge clk);
      chk(ser_valid == 1'b1, "R6 serial valid", longint'(ser_valid), 1);
      chk(done == 1'b0, "R4 no early done", longint'(done), 0);
      got[2*k +: 2] = ser_bits;
      if (poke && k == 3) begin
        load = 1'b1; coef = W'(MAXV); data = W'(MINV);
      end else begin
        load = 1'b0;
      end
    end
    load = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R4 done timing", longint'(done), 1);
    chk(busy == 1'b0, "R4 idle at done", longint'(busy), 0);
    chk(acc_val() == model, poke ? "R8 busy load ignored" : (swp ? "R5 swapped product" : "R2/R3 sum"),
        acc_val(), model);
    chk(longint'(got) == (p & ((64'sd1 <<< (2 * ND)) - 1)), "R6 serial bits",
        longint'(got), p & ((64'sd1 <<< (2 * ND)) - 1));
    @(negedge clk);
    chk(done == 1'b0, "R4 single done", longint'(done), 0);
    chk(acc_val() == model, "R3 sum stable", acc_val(), model);
  endtask

  function automatic longint rnd();
    seed = seed * 1103515245 + 12345;
    return longint'($signed(seed[30:12]));
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(acc_val() == 0, "R1 acc zero", acc_val(), 0);
    chk(busy == 1'b0, "R1 busy low", longint'(busy), 0);
    chk(done == 1'b0, "R1 done low", longint'(done), 0);
  endtask

  task automatic t_simple();
    mac(3, 5, 1'b1, 1'b0, 1'b0);
    mac(-7, 9, 1'b0, 1'b0, 1'b0);
    mac(0, 12345, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_extremes();
    mac(MINV, MINV, 1'b1, 1'b0, 1'b0);
    mac(MINV, MAXV, 1'b1, 1'b0, 1'b0);
    mac(MAXV, MINV, 1'b1, 1'b0, 1'b0);
    mac(MAXV, MAXV, 1'b1, 1'b0, 1'b0);
    mac(-1, MINV, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_full_sum();
    for (int i = 0; i < MT; i++) mac(MINV, MINV, i == 0, 1'b0, 1'b0);
    chk(acc_val() == (64'sd1 <<< 40), "R3 full sum 2^40", acc_val(), 64'sd1 <<< 40);
  endtask

  task automatic t_swap();
    mac(MINV, 77, 1'b1, 1'b1, 1'b0);
    mac(-3, MAXV, 1'b0, 1'b1, 1'b0);
    mac(12345, -54321, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 12; i++) mac(rnd(), rnd(), i == 0, i[0], 1'b0);
  endtask

  task automatic t_busy_load();
    mac(1000, -999, 1'b1, 1'b0, 1'b1);
    mac(-5, -6, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model = 0;
    chk(acc_val() == 0, "R7 clear alone", acc_val(), 0);
    mac(21, 2, 1'b0, 1'b0, 1'b0);
    mac(4, 4, 1'b1, 1'b0, 1'b0);
    chk(acc_val() == 16, "R7 clear with load", acc_val(), 16);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_simple();
    t_extremes();
    t_full_sum();
    t_swap();
    t_random();
    t_busy_load();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule